// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on a byte-wide receive stream and looks at the first six bytes of each frame, which hold the destination address. From that address it decides whether the frame should be kept or dropped. It also labels the frame as unicast, multicast or broadcast. Frames are delimited by a start marker on the first byte and an end marker on the last byte. Only bytes qualified by a valid strobe count.

Unicast frames are compared against a station address and four extra addresses. Multicast frames are looked up in a 64-entry hash table. The table index is built by folding each address byte down to one parity bit. Broadcast frames pass unless a block input is set. A promiscuous input lets every unicast and multicast frame through.

The verdict and the class are held from the moment they are decided until the next frame starts. Logic downstream can sample them at any point up to and including the end of the frame.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, verdict_valid and verdict_accept are 0 and frame_class is 5'b00000. Every hash table entry reads as 0, so a multicast frame is rejected while promisc_en is 0.
- R2: A frame is unicast when bit 0 of its first byte is 0. The first byte carries address bits 47:40, and the sixth byte carries bits 7:0. A unicast frame gets frame_class 5'b10000, where bit 4 means unicast. With promisc_en at 0, it is accepted when its address equals station_addr or any of the four extra addresses. Extra address k sits at extra_addr bits 48k+47:48k.
- R3: With promisc_en at 0, a unicast frame that matches no configured address is rejected. With promisc_en at 1, the same frame is accepted.
- R4: An all-ones destination address is broadcast and gets frame_class 5'b01000, where bit 3 means broadcast. It is accepted when bcast_block is 0 and rejected when bcast_block is 1, whatever the value of promisc_en.
- R5: A frame is multicast when bit 0 of its first byte is 1 and the address is not all ones. A multicast frame gets frame_class 5'b00100, where bit 2 means multicast. Its 6-bit hash index takes bit 5 from the XOR of the eight bits of the first byte, down to bit 0 from the XOR of the sixth byte. The frame is accepted when the table entry at that index is 1 or promisc_en is 1.
- R6: When hash_we is 1 on a rising edge, hash_wdata is stored in table entry hash_waddr. Writing 0 later clears that entry again.
- R7: verdict_valid goes to 1 after the rising edge that follows the edge taking the sixth address byte. It then holds verdict_accept and frame_class unchanged, even through the end marker and through changes to promisc_en or bcast_block. The hold ends when a byte carrying rx_sof is taken, and after that edge all three outputs read 0.
- R8: A frame that ends before its sixth byte produces no verdict. Cycles with rx_valid at 0 do not advance the address count. Bytes arriving between an end marker and the next start marker are ignored. A start marker in the middle of an address restarts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station unicast address |
| extra_addr | input | 192 | Four extra unicast addresses, address k at bits 48k+47:48k |
| promisc_en | input | 1 | Promiscuous mode |
| bcast_block | input | 1 | Reject broadcast frames |
| hash_we | input | 1 | Hash table write strobe |
| hash_waddr | input | 6 | Hash table entry to write |
| hash_wdata | input | 1 | Value written to the entry |
| verdict_valid | output | 1 | Decision present for the current frame |
| verdict_accept | output | 1 | 1 keeps the frame, 0 drops it |
| frame_class | output | 5 | Bit 4 unicast, bit 3 broadcast, bit 2 multicast, bits 1:0 zero |

## Verification
The hardest behaviour to reach from the ports is the hold of a decision that has already been made. To test it, the bench stops a frame just after the sixth address byte. It then changes promisc_en and bcast_block and delivers the end marker before the next frame starts. Only then does it check that nothing moved and that the verdict drops on the new start byte.

Two other sequences also take deliberate stimulus. The first breaks the address with idle cycles between bytes. The second starts a frame, abandons it mid-address with a new start marker, then completes a clean frame. The multicast cases first load the hash table through its write port, using an index the bench computes itself. A later write of 0 clears that entry, and the same frame is then rejected.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CLASS_W = 5;
  localparam int CLS_UNI = 4;
  localparam int CLS_BC  = 3;
  localparam int CLS_MC  = 2;

  typedef enum logic [1:0] {
    KIND_UNI = 2'd0,
    KIND_MC  = 2'd1,
    KIND_BC  = 2'd2
  } da_kind_e;
endpackage

// File: rtl/rxf_reset_sync.sv
module rxf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture #(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_sof,
  input  logic              byte_eof,
  input  logic [7:0]        byte_dat,
  output logic [ADDR_W-1:0] da,
  output logic              da_done
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] da_q, da_d;
  logic              done_q, done_d;
  logic              shift_en;

  // next state
  always_comb begin
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    shift_en = 1'b0;
    if (byte_vld) begin
      if (byte_sof) begin
        shift_en = 1'b1;
        cnt_d    = byte_eof ? '0 : CNT_W'(1);
      end else if (cnt_q != '0) begin
        if (cnt_q < CNT_W'(ADDR_BYTES)) begin
          shift_en = 1'b1;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_BYTES - 1)) done_d = 1'b1;
        end
        if (byte_eof) cnt_d = '0;
      end
    end
    da_d = {da_q[ADDR_W-9:0], byte_dat};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        da_q <= '0;
    else if (shift_en) da_q <= da_d;
  end

  assign da      = da_q;
  assign da_done = done_q;

  // R8: the address counter never runs past the address length
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  // R8: one completion per frame, never on consecutive cycles
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    da_done |=> !da_done);
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int IDX_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wdata,
  output logic [DEPTH-1:0] table_bits
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic entry_q;
    logic entry_en;

    assign entry_en = we && (waddr == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        entry_q <= 1'b0;
      else if (entry_en) entry_q <= wdata;
    end

    assign table_bits[e] = entry_q;
  end

  // R6: a write reaches the addressed entry on that edge
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (table_bits[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_EXTRA  = 4,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int IDX_W  = ADDR_BYTES,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           da,
  input  logic                        da_done,
  input  logic                        frame_start,
  input  logic [ADDR_W-1:0]           station_addr,
  input  logic [NUM_EXTRA*ADDR_W-1:0] extra_addr,
  input  logic                        promisc_en,
  input  logic                        bcast_block,
  input  logic [DEPTH-1:0]            table_bits,
  output logic                        verdict_valid,
  output logic                        verdict_accept,
  output logic [CLASS_W-1:0]          frame_class
);
  logic [IDX_W-1:0]     hash_idx;
  logic [NUM_EXTRA-1:0] extra_hit;
  logic                 uni_hit;
  da_kind_e             kind;
  logic                 accept_now;
  logic [CLASS_W-1:0]   class_now;

  logic                 valid_q, valid_d;
  logic                 accept_q, accept_d;
  logic [CLASS_W-1:0]   class_q, class_d;
  logic                 upd_en;

  // one parity bit per address byte; the last byte received lands in bit 0
  for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_fold
    assign hash_idx[j] = ^da[8*j +: 8];
  end

  for (genvar k = 0; k < NUM_EXTRA; k++) begin : g_extra
    assign extra_hit[k] = (da == extra_addr[k*ADDR_W +: ADDR_W]);
  end

  assign uni_hit = (da == station_addr) || (|extra_hit);

  always_comb begin
    if (&da)                  kind = KIND_BC;
    else if (da[ADDR_W-8])    kind = KIND_MC;
    else                      kind = KIND_UNI;

    class_now = '0;
    case (kind)
      KIND_BC: begin
        class_now[CLS_BC] = 1'b1;
        accept_now        = !bcast_block;
      end
      KIND_MC: begin
        class_now[CLS_MC] = 1'b1;
        accept_now        = promisc_en || table_bits[hash_idx];
      end
      default: begin
        class_now[CLS_UNI] = 1'b1;
        accept_now         = promisc_en || uni_hit;
      end
    endcase
  end

  // next state
  always_comb begin
    upd_en   = frame_start || da_done;
    valid_d  = valid_q;
    accept_d = accept_q;
    class_d  = class_q;
    if (frame_start) begin
      valid_d  = 1'b0;
      accept_d = 1'b0;
      class_d  = '0;
    end else if (da_done) begin
      valid_d  = 1'b1;
      accept_d = accept_now;
      class_d  = class_now;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      class_q  <= '0;
    end else if (upd_en) begin
      valid_q  <= valid_d;
      accept_q <= accept_d;
      class_q  <= class_d;
    end
  end

  assign verdict_valid  = valid_q;
  assign verdict_accept = accept_q;
  assign frame_class    = class_q;

  // R1: no decision means quiet outputs
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (frame_class == '0 && !verdict_accept));

  // R5: a decided frame carries exactly one class
  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> ($countones(frame_class) == 1));

  // R7: a new frame start withdraws the verdict
  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !verdict_valid);

  // R7: the verdict holds until the next frame start
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !frame_start) |=>
      (verdict_valid && $stable(verdict_accept) && $stable(frame_class)));

  // R4: a blocked broadcast is dropped
  assert_bcast_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (da_done && !frame_start && (&da) && bcast_block) |=> !verdict_accept);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_EXTRA  = 4,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int IDX_W  = ADDR_BYTES,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  input  logic                        rx_sof,
  input  logic                        rx_eof,
  input  logic [7:0]                  rx_byte,
  input  logic [ADDR_W-1:0]           station_addr,
  input  logic [NUM_EXTRA*ADDR_W-1:0] extra_addr,
  input  logic                        promisc_en,
  input  logic                        bcast_block,
  input  logic                        hash_we,
  input  logic [IDX_W-1:0]            hash_waddr,
  input  logic                        hash_wdata,
  output logic                        verdict_valid,
  output logic                        verdict_accept,
  output logic [CLASS_W-1:0]          frame_class
);
  logic              rst_i_n;
  logic [ADDR_W-1:0] da;
  logic              da_done;
  logic [DEPTH-1:0]  table_bits;
  logic              frame_start;

  assign frame_start = rx_valid && rx_sof;

  rxf_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rxf_da_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .byte_vld (rx_valid),
    .byte_sof (rx_sof),
    .byte_eof (rx_eof),
    .byte_dat (rx_byte),
    .da       (da),
    .da_done  (da_done)
  );

  rxf_hash_table #(.IDX_W(IDX_W)) u_hash (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .we         (hash_we),
    .waddr      (hash_waddr),
    .wdata      (hash_wdata),
    .table_bits (table_bits)
  );

  rxf_verdict #(.ADDR_BYTES(ADDR_BYTES), .NUM_EXTRA(NUM_EXTRA)) u_dec (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .da             (da),
    .da_done        (da_done),
    .frame_start    (frame_start),
    .station_addr   (station_addr),
    .extra_addr     (extra_addr),
    .promisc_en     (promisc_en),
    .bcast_block    (bcast_block),
    .table_bits     (table_bits),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .frame_class    (frame_class)
  );
endmodule

// File: tb/sim_rx_da_filter.sv
`timescale 1ns/1ps
module sim_rx_da_filter;
  localparam logic [47:0] STA    = 48'h02_11_22_33_44_55;
  localparam logic [47:0] ALT0   = 48'h00_AA_BB_CC_DD_01;
  localparam logic [47:0] ALT1   = 48'h00_AA_BB_CC_DD_02;
  localparam logic [47:0] ALT2   = 48'h00_AA_BB_CC_DD_03;
  localparam logic [47:0] ALT3   = 48'h00_AA_BB_CC_DD_04;
  localparam logic [47:0] UNK    = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC_HIT = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC_MIS = 48'h33_33_00_00_00_01;

  // {da, promisc, bcast_block, expected accept, expected class}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {STA,    1'b0, 1'b0, 1'b1, 5'b10000},  // R2
    {ALT0,   1'b0, 1'b0, 1'b1, 5'b10000},  // R2
    {ALT1,   1'b0, 1'b0, 1'b1, 5'b10000},  // R2
    {ALT2,   1'b0, 1'b0, 1'b1, 5'b10000},  // R2
    {ALT3,   1'b0, 1'b0, 1'b1, 5'b10000},  // R2
    {UNK,    1'b0, 1'b0, 1'b0, 5'b10000},  // R3
    {UNK,    1'b1, 1'b0, 1'b1, 5'b10000},  // R3
    {BCAST,  1'b0, 1'b0, 1'b1, 5'b01000},  // R4
    {BCAST,  1'b0, 1'b1, 1'b0, 5'b01000},  // R4
    {BCAST,  1'b1, 1'b1, 1'b0, 5'b01000},  // R4
    {MC_HIT, 1'b0, 1'b0, 1'b1, 5'b00100},  // R5
    {MC_MIS, 1'b0, 1'b0, 1'b0, 5'b00100},  // R5
    {MC_MIS, 1'b1, 1'b0, 1'b1, 5'b00100}   // R5
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rx_valid, rx_sof, rx_eof;
  logic [7:0]   rx_byte;
  logic [47:0]  station_addr;
  logic [191:0] extra_addr;
  logic         promisc_en, bcast_block;
  logic         hash_we;
  logic [5:0]   hash_waddr;
  logic         hash_wdata;
  logic         verdict_valid, verdict_accept;
  logic [4:0]   frame_class;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rx_da_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_byte(rx_byte), .station_addr(station_addr),
    .extra_addr(extra_addr), .promisc_en(promisc_en), .bcast_block(bcast_block),
    .hash_we(hash_we), .hash_waddr(hash_waddr), .hash_wdata(hash_wdata),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .frame_class(frame_class)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [5:0] r;
    for (int j = 0; j < 6; j++) r[j] = ^a[8*j +: 8];
    return r;
  endfunction

  task automatic put(input logic [7:0] d, input bit s, input bit e);
    rx_valid = 1'b1; rx_sof = s; rx_eof = e; rx_byte = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic send(input logic [47:0] da, input int pay);
    for (int i = 0; i < 6; i++) put(da[47-8*i -: 8], i == 0, (pay == 0) && (i == 5));
    for (int p = 0; p < pay; p++) put(8'(p + 1), 1'b0, p == pay - 1);
  endtask

  task automatic hwrite(input logic [5:0] a, input logic v);
    hash_we = 1'b1; hash_waddr = a; hash_wdata = v;
    @(negedge clk);
    hash_we = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_byte = '0;
    station_addr = STA; extra_addr = {ALT3, ALT2, ALT1, ALT0};
    promisc_en = 1'b0; bcast_block = 1'b0;
    hash_we = 1'b0; hash_waddr = '0; hash_wdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(verdict_valid == 1'b0, "R1 valid", 64'(verdict_valid), 0);
    chk(verdict_accept == 1'b0, "R1 accept", 64'(verdict_accept), 0);
    chk(frame_class == 5'b0, "R1 class", 64'(frame_class), 0);
    // R1 table empty: hit address rejected before any write
    send(MC_HIT, 2);
    chk(verdict_accept == 1'b0, "R1 empty table", 64'(verdict_accept), 0);
    @(negedge clk);

    hwrite(hidx(MC_HIT), 1'b1);  // R6 load entry

    for (int v = 0; v < NV; v++) begin
      promisc_en  = VEC[v][7];
      bcast_block = VEC[v][6];
      send(VEC[v][55:8], 4);
      chk(verdict_valid == 1'b1, $sformatf("R7 valid vec%0d", v), 64'(verdict_valid), 1);
      chk(verdict_accept == VEC[v][5], $sformatf("R2-5 accept vec%0d", v), 64'(verdict_accept), 64'(VEC[v][5]));
      chk(frame_class == VEC[v][4:0], $sformatf("R2-5 class vec%0d", v), 64'(frame_class), 64'(VEC[v][4:0]));
      @(negedge clk);
    end
    promisc_en = 1'b0; bcast_block = 1'b0;

    // R7 exact latency and hold
    for (int i = 0; i < 6; i++) put(UNK[47-8*i -: 8], i == 0, 1'b0);
    chk(verdict_valid == 1'b0, "R7 not yet", 64'(verdict_valid), 0);
    @(negedge clk);
    chk(verdict_valid == 1'b1, "R7 decided", 64'(verdict_valid), 1);
    chk(verdict_accept == 1'b0, "R7 reject unk", 64'(verdict_accept), 0);
    promisc_en = 1'b1; bcast_block = 1'b1;
    repeat (2) @(negedge clk);
    chk(verdict_accept == 1'b0, "R7 hold vs cfg", 64'(verdict_accept), 0);
    put(8'h77, 1'b0, 1'b1);
    @(negedge clk);
    chk(verdict_valid == 1'b1, "R7 hold past eof", 64'(verdict_valid), 1);
    chk(frame_class == 5'b10000, "R7 class held", 64'(frame_class), 64'h10);
    promisc_en = 1'b0; bcast_block = 1'b0;
    put(STA[47:40], 1'b1, 1'b0);
    chk(verdict_valid == 1'b0, "R7 clear on sof", 64'(verdict_valid), 0);
    chk(frame_class == 5'b0, "R7 class cleared", 64'(frame_class), 0);
    put(8'h00, 1'b0, 1'b1);

    // R8 runt frame and stray bytes
    put(8'h02, 1'b1, 1'b0); put(8'h11, 1'b0, 1'b0);
    put(8'h22, 1'b0, 1'b0); put(8'h33, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) put(8'h44 + 8'(i), 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(verdict_valid == 1'b0, "R8 runt/stray", 64'(verdict_valid), 0);

    // R8 idle gaps inside the address
    for (int i = 0; i < 6; i++) begin
      put(ALT2[47-8*i -: 8], i == 0, 1'b0);
      repeat (i + 1) @(negedge clk);
    end
    @(negedge clk);
    chk(verdict_valid == 1'b1, "R8 gaps valid", 64'(verdict_valid), 1);
    chk(verdict_accept == 1'b1, "R8 gaps accept", 64'(verdict_accept), 1);
    put(8'h00, 1'b0, 1'b1);

    // R8 restart mid-address
    put(8'h00, 1'b1, 1'b0); put(8'h99, 1'b0, 1'b0); put(8'h98, 1'b0, 1'b0);
    send(STA, 2);
    chk(verdict_accept == 1'b1, "R8 restart accept", 64'(verdict_accept), 1);
    chk(frame_class == 5'b10000, "R8 restart class", 64'(frame_class), 64'h10);
    @(negedge clk);

    // R6 clear one entry, set another
    hwrite(hidx(MC_HIT), 1'b0);
    hwrite(hidx(MC_MIS), 1'b1);
    send(MC_HIT, 2);
    chk(verdict_accept == 1'b0, "R6 cleared entry", 64'(verdict_accept), 0);
    send(MC_MIS, 2);
    chk(verdict_accept == 1'b1, "R6 set entry", 64'(verdict_accept), 1);
    chk(frame_class == 5'b00100, "R5 class", 64'(frame_class), 64'h4);

    summary();
    $finish;
  end
endmodule